// File: doc/BRIEF.md
# Transmit Packet Framer for a 2.4 GHz Low-Rate PHY

This block sits between a host interface and a symbol generator on the transmit side of a low-rate personal-area-network radio. For each frame it produces a byte stream made of a synchronisation header, a length byte, the payload and a 16-bit frame check sequence. The frame check sequence is computed inline while the payload goes out. The symbol generator takes one byte each time it pulses its request line, and the framer presents each byte ahead of that pulse.

The payload can reach the framer in one of two ways. In buffered mode the host writes the whole payload into an internal byte buffer, then starts the frame. The framer pulses a completion interrupt once the last check byte has been taken. In stream mode the host supplies the payload one word at a time. The framer pulses a data-request interrupt each time its one-word staging register is empty and more payload is still owed. If the symbol generator asks for a payload byte before the host has supplied it, the framer flags an underrun and abandons the frame. A length above the payload limit is refused at start and nothing goes out.

Top module: `pkt_framer`

## Requirements
- R1: A frame opens with four 0x00 bytes, then the delimiter byte 0xA7, then one length byte equal to the payload length plus 2.
- R2: After the length byte, the payload bytes follow in order. In buffered mode these are buffer entries 0 to len-1. In stream mode they are the words in the order the host supplied them.
- R3: The last two bytes are a CRC-16 with generator x^16+x^12+x^5+1 and initial value 0. It is computed bit 0 first over the payload bytes only, and its low byte is sent before its high byte.
- R4: In buffered mode `doneIrq` pulses for exactly one cycle, once per frame, after the final check byte is taken. In stream mode it never pulses.
- R5: In stream mode `reqIrq` pulses once for each payload word, so exactly len pulses occur in a complete frame. It pulses only while the staging register is empty. A supplied word is held until the symbol generator consumes it.
- R6: In stream mode, if `symReq` arrives for a payload byte while the staging register is empty, then `underrun` rises and the frame is aborted. The framer goes idle, `txValid` drops and no completion pulse follows.
- R7: A start with `txLen` greater than 125 sets `lenErr` and leaves the framer idle, with `txValid` low. A length of exactly 125 is accepted.
- R8: While a frame is in progress, `txStart`, `txLen` and `streamMode` are ignored, and the frame in flight is unchanged.
- R9: After reset, `busy`, `txValid`, `doneIrq`, `reqIrq`, `lenErr` and `underrun` are all low.
- R10: A start with an acceptable length clears both `lenErr` and `underrun`.
- R11: A zero-length payload yields an 8-byte frame: the header bytes, a length byte of 2, and a check value of 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| streamMode | input | 1 | Feed mode, sampled at start: 1 selects stream mode, 0 selects buffered mode |
| txLen | input | 8 | Payload length, sampled at start |
| txStart | input | 1 | Start pulse, honoured only when idle |
| bufWrEn | input | 1 | Payload buffer write enable |
| bufWrAddr | input | 7 | Payload buffer write index |
| bufWrData | input | 8 | Payload buffer write data |
| wordValid | input | 1 | Stream word present |
| wordData | input | 8 | Stream word |
| symReq | input | 1 | Symbol generator takes the presented byte at this edge |
| txValid | output | 1 | `txData` holds a byte ready to be taken |
| txData | output | 8 | Byte presented to the symbol generator |
| busy | output | 1 | A frame is in progress |
| doneIrq | output | 1 | Buffered-mode completion pulse |
| reqIrq | output | 1 | Stream-mode data-request pulse |
| lenErr | output | 1 | Last start was refused for length |
| underrun | output | 1 | Last stream frame ran dry and was aborted |

## Verification
The assertions assume the host drives `wordValid` for one cycle only in answer to a `reqIrq` pulse. They also assume the host leaves the payload buffer alone while a buffered frame is in flight. The stimulus keeps to these rules: the host process answers each request at most once, at the next falling edge, and all buffer writes finish before the start pulse. `symReq` is paced at one pulse in four cycles. This leaves a host that answers promptly enough time to refill the staging register before each pull. Underrun is reached only by having the host deliberately stop answering.

// File: rtl/framer_pkg.sv
package framer_pkg;
  parameter int MAX_PAYLOAD = 125;
  parameter int PRE_COUNT = 4;
  parameter int LEN_W = 8;
  parameter int IDX_W = $clog2(MAX_PAYLOAD);
  parameter int FCS_BYTES = 2;
  parameter logic [7:0] PRE_BYTE = 8'h00;
  parameter logic [7:0] SFD_BYTE = 8'hA7;
  parameter logic [15:0] CRC_POLY_REV = 16'h8408;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_SFD, ST_LEN, ST_PAY, ST_FCS_LO, ST_FCS_HI
  } fstate_t;

  typedef struct packed {
    logic crcClr;
    logic crcEn;
    logic stageClr;
    logic stageTake;
    logic acceptWord;
    logic useStage;
    fstate_t sel;
    logic [IDX_W-1:0] idx;
  } dp_ctl_t;

  function automatic logic [15:0] crcStep(logic [15:0] crcIn, logic [7:0] dataIn);
    logic [15:0] c;
    c = crcIn;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ dataIn[b]) c = (c >> 1) ^ CRC_POLY_REV;
      else c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import framer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             txStart,
  input  logic             streamMode,
  input  logic [LEN_W-1:0] txLen,
  input  logic             symReq,
  input  logic             stageFull,
  input  logic             wordTaken,
  output dp_ctl_t          ctl,
  output logic [LEN_W-1:0] frameLen,
  output logic             txValid,
  output logic             busy,
  output logic             doneIrq,
  output logic             reqIrq,
  output logic             lenErr,
  output logic             underrun
);
  fstate_t state;
  logic [IDX_W-1:0] cnt;
  logic [IDX_W-1:0] fetchCnt;
  logic [LEN_W-1:0] lenQ;
  logic modeQ;
  logic reqPending;
  logic startOk, starve, take, underrunHit, lastPay, wordsOwed;

  assign startOk     = (state == ST_IDLE) && txStart && (txLen <= LEN_W'(MAX_PAYLOAD));
  assign starve      = (state == ST_PAY) && modeQ && !stageFull;
  assign txValid     = (state != ST_IDLE) && !starve;
  assign take        = symReq && txValid;
  assign underrunHit = starve && symReq;
  assign lastPay     = (LEN_W'(cnt) == lenQ - LEN_W'(1));
  assign wordsOwed   = LEN_W'(fetchCnt) < lenQ;
  assign busy        = (state != ST_IDLE);
  assign frameLen    = lenQ;

  always_comb begin
    ctl.crcClr     = startOk;
    ctl.crcEn      = take && (state == ST_PAY);
    ctl.stageClr   = startOk;
    ctl.stageTake  = take && (state == ST_PAY) && modeQ;
    ctl.acceptWord = busy && modeQ && wordsOwed;
    ctl.useStage   = modeQ;
    ctl.sel        = state;
    ctl.idx        = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      fetchCnt   <= '0;
      lenQ       <= '0;
      modeQ      <= 1'b0;
      reqPending <= 1'b0;
      doneIrq    <= 1'b0;
      reqIrq     <= 1'b0;
      lenErr     <= 1'b0;
      underrun   <= 1'b0;
    end else begin
      doneIrq <= 1'b0;
      reqIrq  <= 1'b0;
      if (wordTaken) begin
        reqPending <= 1'b0;
        fetchCnt   <= fetchCnt + 1'b1;
      end else if (busy && modeQ && !stageFull && wordsOwed && !reqPending) begin
        reqIrq     <= 1'b1;
        reqPending <= 1'b1;
      end
      case (state)
        ST_IDLE: if (txStart) begin
          underrun <= 1'b0;
          if (!startOk) begin
            lenErr <= 1'b1;
          end else begin
            lenErr     <= 1'b0;
            state      <= ST_PRE;
            cnt        <= '0;
            fetchCnt   <= '0;
            reqPending <= 1'b0;
            lenQ       <= txLen;
            modeQ      <= streamMode;
          end
        end
        ST_PRE: if (take) begin
          if (cnt == IDX_W'(PRE_COUNT - 1)) begin
            state <= ST_SFD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SFD: if (take) state <= ST_LEN;
        ST_LEN: if (take) begin
          cnt   <= '0;
          state <= (lenQ == '0) ? ST_FCS_LO : ST_PAY;
        end
        ST_PAY: begin
          if (underrunHit) begin
            state    <= ST_IDLE;
            underrun <= 1'b1;
          end else if (take) begin
            if (lastPay) state <= ST_FCS_LO;
            else cnt <= cnt + 1'b1;
          end
        end
        ST_FCS_LO: if (take) state <= ST_FCS_HI;
        ST_FCS_HI: if (take) begin
          state   <= ST_IDLE;
          doneIrq <= !modeQ;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a refused start leaves the framer idle and silent
  assert_reject_stays_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lenErr) |-> (state == ST_IDLE) && !txValid);
  // R4: completion is a single-cycle pulse
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);
  // R4: completion only in buffered mode, after the frame has ended
  assert_done_packet_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> !modeQ && (state == ST_IDLE));
  // R6: an underrun aborts the frame without completion
  assert_underrun_aborts_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> (state == ST_IDLE) && !doneIrq);
  // R5: requests only in stream mode and never beyond the frame length
  assert_req_bounded_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqIrq |-> modeQ && (LEN_W'(fetchCnt) <= lenQ) && !stageFull);
  // R8: a start during a frame does not disturb the latched length or mode
  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && txStart) |=> $stable(lenQ) && $stable(modeQ));
endmodule

// File: rtl/framer_dpath.sv
module framer_dpath
  import framer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dp_ctl_t          ctl,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             bufWrEn,
  input  logic [IDX_W-1:0] bufWrAddr,
  input  logic [7:0]       bufWrData,
  input  logic             wordValid,
  input  logic [7:0]       wordData,
  output logic             stageFull,
  output logic             wordTaken,
  output logic [7:0]       txData
);
  logic [7:0]  payBuf [MAX_PAYLOAD];
  logic [7:0]  stageData;
  logic [7:0]  payByte;
  logic [15:0] crcReg;

  always_ff @(posedge clk) begin
    if (bufWrEn && (bufWrAddr < IDX_W'(MAX_PAYLOAD))) payBuf[bufWrAddr] <= bufWrData;
  end

  assign wordTaken = wordValid && ctl.acceptWord && !stageFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageFull <= 1'b0;
      stageData <= '0;
    end else if (ctl.stageClr) begin
      stageFull <= 1'b0;
    end else if (wordTaken) begin
      stageFull <= 1'b1;
      stageData <= wordData;
    end else if (ctl.stageTake) begin
      stageFull <= 1'b0;
    end
  end

  assign payByte = ctl.useStage ? stageData : payBuf[ctl.idx];

  always_ff @(posedge clk) begin
    if (!rstN || ctl.crcClr) crcReg <= '0;
    else if (ctl.crcEn) crcReg <= crcStep(crcReg, payByte);
  end

  always_comb begin
    case (ctl.sel)
      ST_PRE:    txData = PRE_BYTE;
      ST_SFD:    txData = SFD_BYTE;
      ST_LEN:    txData = frameLen + LEN_W'(FCS_BYTES);
      ST_PAY:    txData = payByte;
      ST_FCS_LO: txData = crcReg[7:0];
      ST_FCS_HI: txData = crcReg[15:8];
      default:   txData = '0;
    endcase
  end

  // R5: a held word is neither lost nor altered until it is consumed
  assert_stage_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stageFull && !ctl.stageTake && !ctl.stageClr) |=> stageFull && $stable(stageData));
  // R3: the check value only moves while payload bytes are taken
  assert_crc_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.crcEn && !ctl.crcClr) |=> $stable(crcReg));
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
  import framer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             streamMode,
  input  logic [LEN_W-1:0] txLen,
  input  logic             txStart,
  input  logic             bufWrEn,
  input  logic [IDX_W-1:0] bufWrAddr,
  input  logic [7:0]       bufWrData,
  input  logic             wordValid,
  input  logic [7:0]       wordData,
  input  logic             symReq,
  output logic             txValid,
  output logic [7:0]       txData,
  output logic             busy,
  output logic             doneIrq,
  output logic             reqIrq,
  output logic             lenErr,
  output logic             underrun
);
  dp_ctl_t ctl;
  logic [LEN_W-1:0] frameLen;
  logic stageFull, wordTaken;

  framer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txStart(txStart), .streamMode(streamMode),
    .txLen(txLen), .symReq(symReq), .stageFull(stageFull), .wordTaken(wordTaken),
    .ctl(ctl), .frameLen(frameLen), .txValid(txValid), .busy(busy),
    .doneIrq(doneIrq), .reqIrq(reqIrq), .lenErr(lenErr), .underrun(underrun)
  );

  framer_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .frameLen(frameLen),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData),
    .wordValid(wordValid), .wordData(wordData),
    .stageFull(stageFull), .wordTaken(wordTaken), .txData(txData)
  );
endmodule

// File: tb/tb_pkt_framer.sv
module tb_pkt_framer;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, streamMode, txStart, bufWrEn, wordValid, symReq;
  logic [7:0] txLen, bufWrData, wordData, txData;
  logic [6:0] bufWrAddr;
  logic txValid, busy, doneIrq, reqIrq, lenErr, underrun;

  pkt_framer dut (
    .clk(clk), .rstN(rstN), .streamMode(streamMode), .txLen(txLen), .txStart(txStart),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData),
    .wordValid(wordValid), .wordData(wordData), .symReq(symReq),
    .txValid(txValid), .txData(txData), .busy(busy), .doneIrq(doneIrq),
    .reqIrq(reqIrq), .lenErr(lenErr), .underrun(underrun)
  );

  int nChecks = 0, nFail = 0;
  bit finished = 0;
  logic [7:0] got [200];
  int nGot, nReq, nDone;

  // {stream, len[6:0], seed[7:0]}
  localparam logic [15:0] VEC [8] = '{
    {1'b0, 7'd5,   8'h11}, {1'b0, 7'd1,   8'h22}, {1'b0, 7'd0,  8'h33},
    {1'b1, 7'd3,   8'h44}, {1'b1, 7'd20,  8'h55}, {1'b0, 7'd125, 8'h66},
    {1'b1, 7'd125, 8'h77}, {1'b1, 7'd1,   8'h88}};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] genByte(input int seed, input int i);
    return 8'(seed * 31 + i * 17 + (i >> 3));
  endfunction

  function automatic logic [15:0] refFcs(input int seed, input int len);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < len; i++) begin
      logic [7:0] d = genByte(seed, i);
      for (int b = 0; b < 8; b++) begin
        if (c[0] ^ d[b]) c = (c >> 1) ^ 16'h8408;
        else c = c >> 1;
      end
    end
    return c;
  endfunction

  task automatic runFrame(input bit mode, input int len, input int seed,
                          input int dropAfter, input bit poke);
    int hostPtr = 0;
    nGot = 0; nReq = 0; nDone = 0;
    if (!mode) begin
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        bufWrEn = 1; bufWrAddr = 7'(i); bufWrData = genByte(seed, i);
      end
      @(negedge clk); bufWrEn = 0;
    end
    @(negedge clk);
    streamMode = mode; txLen = 8'(len); txStart = 1;
    @(negedge clk);
    txStart = 0;
    for (int c = 0; c < (len + 8) * 4 + 40; c++) begin
      @(negedge clk);
      if (reqIrq) nReq++;
      if (doneIrq) nDone++;
      if (reqIrq && hostPtr < dropAfter) begin
        wordValid = 1; wordData = genByte(seed, hostPtr); hostPtr++;
      end else begin
        wordValid = 0;
      end
      symReq = (c % 4 == 0);
      if (symReq && txValid) begin
        got[nGot] = txData; nGot++;
      end
      if (poke && c == 30) begin
        txStart = 1; txLen = 8'd3; streamMode = !mode;
      end else begin
        txStart = 0;
      end
    end
    @(negedge clk);
    symReq = 0; wordValid = 0; txStart = 0;
  endtask

  task automatic checkFrame(input int len, input int seed);
    logic [15:0] fcs = refFcs(seed, len);
    bit hdrOk = 1, payOk = 1;
    int badPay = -1;
    check(nGot == len + 8, "R1", "frame byte count", nGot, len + 8);
    if (nGot == len + 8) begin
      for (int i = 0; i < 4; i++) if (got[i] != 8'h00) hdrOk = 0;
      if (got[4] != 8'hA7) hdrOk = 0;
      check(hdrOk, "R1", "preamble/delimiter", got[4], 8'hA7);
      check(got[5] == 8'(len + 2), "R1", "length byte", got[5], len + 2);
      for (int i = 0; i < len; i++)
        if (got[6 + i] != genByte(seed, i) && badPay < 0) begin payOk = 0; badPay = i; end
      if (!payOk) check(0, "R2", "payload byte", got[6 + badPay], genByte(seed, badPay));
      else check(1, "R2", "payload", 0, 0);
      check({got[len + 7], got[len + 6]} == fcs, "R3", "check sequence",
            {got[len + 7], got[len + 6]}, fcs);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 0; streamMode = 0; txStart = 0; txLen = 0; bufWrEn = 0; bufWrAddr = 0;
    bufWrData = 0; wordValid = 0; wordData = 0; symReq = 0;
    repeat (3) @(negedge clk);
    check({busy, txValid, doneIrq, reqIrq, lenErr, underrun} == 6'b0, "R9",
          "reset outputs", {busy, txValid, doneIrq, reqIrq, lenErr, underrun}, 0);
    rstN = 1;

    // table walk: R1 R2 R3 R4 R5 R11 (len 0) and R7 (len 125 accepted)
    for (int v = 0; v < 8; v++) begin
      bit m = VEC[v][15];
      int l = int'(VEC[v][14:8]);
      int s = int'(VEC[v][7:0]);
      runFrame(m, l, s, l, 0);
      checkFrame(l, s);
      check(nDone == (m ? 0 : 1), "R4", "completion pulses", nDone, m ? 0 : 1);
      check(nReq == (m ? l : 0), "R5", "request pulses", nReq, m ? l : 0);
      check(!busy && !underrun, "R6", "frame ended clean", {busy, underrun}, 0);
      if (l == 0) check(nGot == 8, "R11", "empty frame size", nGot, 8);
    end

    // R7: oversize lengths refused, nothing sent
    foreach (VEC[k]) if (k < 2) begin
      bit sawValid = 0;
      @(negedge clk); streamMode = 0; txLen = (k == 0) ? 8'd126 : 8'd255; txStart = 1;
      @(negedge clk); txStart = 0;
      check(lenErr && !busy, "R7", "oversize refused", {lenErr, busy}, 2'b10);
      for (int c = 0; c < 20; c++) begin
        @(negedge clk); symReq = 1;
        if (txValid) sawValid = 1;
      end
      @(negedge clk); symReq = 0;
      check(!sawValid, "R7", "no bytes after refusal", sawValid, 0);
    end

    // R10: good start clears lenErr
    runFrame(0, 2, 9, 2, 0);
    checkFrame(2, 9);
    check(!lenErr, "R10", "lenErr cleared", lenErr, 0);

    // R6: host stops answering after 3 words
    runFrame(1, 10, 5, 3, 0);
    check(underrun && !busy && !txValid, "R6", "underrun abort",
          {underrun, busy, txValid}, 3'b100);
    check(nGot == 9, "R6", "bytes before abort", nGot, 9);
    check(nGot == 9 && got[8] == genByte(5, 2), "R6", "last byte before abort", got[8],
          genByte(5, 2));
    check(nDone == 0 && nReq == 4, "R6", "no completion, 4 requests", {nDone, nReq}, 4);

    // R10: good start clears underrun
    runFrame(0, 4, 3, 4, 0);
    checkFrame(4, 3);
    check(!underrun, "R10", "underrun cleared", underrun, 0);

    // R8: start with other length and mode during a frame is ignored
    runFrame(0, 20, 12, 20, 1);
    checkFrame(20, 12);
    check(nDone == 1 && nReq == 0, "R8", "frame undisturbed", {nDone, nReq}, 16'h0100);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule